// File: doc/BRIEF.md
# Sensor Row Dark-Level Corrector

This block takes a raw image frame from an external sensor, one pixel per accepted transfer, and removes a per-row dark offset before the frame is made available to a host processor. Every sensor row carries 64 exposed pixels followed by 2 light-shielded pixels. The shielded pair measures the offset that the sensor adds to that row. Once the pair has arrived, the block averages it and subtracts the average from each exposed pixel of the row, clamping at zero. The result goes into a 64x64 frame memory.

The host starts a capture by writing to the control address. It can poll a busy flag at that address, or watch the `busy` pin. When the capture has finished, it reads corrected pixels back by address. The sensor side uses a valid/ready handshake. Pixel intake opens only while the block is collecting a row, and it closes while the row is being corrected.

Top module: `row_bias_corrector`

## Requirements
- R1: A frame is 64 rows of 66 accepted pixels. Row positions 0..63 are exposed pixels and are stored. Positions 64 and 65 are shielded pixels and are never stored in the frame.
- R2: The row offset is the 9-bit sum of the two shielded pixels shifted right by one, so an odd sum truncates (3 and 4 give 3, 200 and 201 give 200).
- R3: Each stored pixel equals the exposed pixel minus the row offset, or 0 when the offset is larger.
- R4: A host read with `host_addr[12]` = 0 returns the stored pixel at row*64+col (address bits 11..0) on `host_rdata` at the clock edge after the one that sampled `host_rd`.
- R5: A host write with `host_addr[12]` = 1 while idle starts a capture. `busy` and `pix_ready` are high after that edge.
- R6: A pixel is taken only on an edge where both `pix_valid` and `pix_ready` are high. `pix_data` offered with `pix_valid` low has no effect on the stored frame.
- R7: `pix_ready` falls at the edge that accepts a row's second shielded pixel. It rises again exactly 66 edges later, unless that row was the last one.
- R8: `busy` falls exactly 66 edges after the last row's second shielded pixel is accepted, and stays low until the next start. A start write while busy is ignored.
- R9: A host read with `host_addr[12]` = 1 returns the busy flag in bit 0 and zeros in bits 7..1, one cycle later.
- R10: After reset, `busy`, `pix_ready` and `host_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Sensor pixel offered |
| pix_data | input | 8 | Sensor pixel value (0 dark, 255 bright) |
| pix_ready | output | 1 | Block is collecting a row and will take a pixel |
| host_addr | input | 13 | Bit 12 selects control; bits 11..0 address the frame |
| host_wr | input | 1 | Host write strobe (start when bit 12 set) |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read data, one cycle after the strobe |
| busy | output | 1 | Capture in progress |

## Verification
Host read data is due one edge after the strobe. The bench raises the strobe at a falling edge and samples at the next falling edge, one rising edge later. Row correction takes a fixed 66 edges after the second shielded pixel is accepted. The bench counts exactly that many falling edges before checking that `pix_ready` is back for the next row, and `busy` for the last row, checking the cycle before as well so that an early or late release is caught. Pixels are offered at falling edges and counted as accepted only on an edge where `pix_ready` was already high.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  localparam int SHIELD_PIX = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_ROW,
    ST_CALC_BIAS,
    ST_FIX_ROW,
    ST_NEXT_ROW
  } rbc_state_e;
endpackage

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  localparam int LINE_LEN = COLS + SHIELD_PIX,
  localparam int CW = $clog2(LINE_LEN),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          pix_valid,
  output rbc_state_e    state,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          busy,
  output logic          pix_ready
);
  rbc_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:      if (start) nxt = ST_GET_ROW;
      ST_GET_ROW:   if (pix_valid && col == CW'(LINE_LEN - 1)) nxt = ST_CALC_BIAS;
      ST_CALC_BIAS: nxt = ST_FIX_ROW;
      ST_FIX_ROW:   if (col == CW'(COLS - 1)) nxt = ST_NEXT_ROW;
      ST_NEXT_ROW:  nxt = (row == RW'(ROWS - 1)) ? ST_IDLE : ST_GET_ROW;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      col       <= '0;
      row       <= '0;
      busy      <= 1'b0;
      pix_ready <= 1'b0;
    end else begin
      state     <= nxt;
      busy      <= (nxt != ST_IDLE);
      pix_ready <= (nxt == ST_GET_ROW);
      case (state)
        ST_IDLE: begin
          col <= '0;
          row <= '0;
        end
        ST_GET_ROW:
          if (pix_valid) col <= (col == CW'(LINE_LEN - 1)) ? '0 : col + 1'b1;
        ST_CALC_BIAS:
          col <= '0;
        ST_FIX_ROW:
          col <= (col == CW'(COLS - 1)) ? '0 : col + 1'b1;
        ST_NEXT_ROW: begin
          row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
          col <= '0;
        end
        default: col <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rbc_line_store.sv
module rbc_line_store
  import rbc_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int PIX_W = 8,
  localparam int CW = $clog2(COLS + SHIELD_PIX),
  localparam int IW = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [CW-1:0]    wcol,
  input  logic [PIX_W-1:0] wdata,
  input  logic [CW-1:0]    rcol,
  output logic [PIX_W-1:0] rdata,
  output logic [PIX_W-1:0] shield_a,
  output logic [PIX_W-1:0] shield_b
);
  logic [PIX_W-1:0] line_q [COLS];

  always_ff @(posedge clk) begin
    if (we && wcol < CW'(COLS)) line_q[wcol[IW-1:0]] <= wdata;
    if (we && wcol == CW'(COLS)) shield_a <= wdata;
    if (we && wcol == CW'(COLS + 1)) shield_b <= wdata;
  end

  assign rdata = line_q[rcol[IW-1:0]];
endmodule

// File: rtl/rbc_bias_fix.sv
module rbc_bias_fix #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIX_W-1:0] shield_a,
  input  logic [PIX_W-1:0] shield_b,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] pix_out
);
  logic [PIX_W:0]   sum;
  logic [PIX_W-1:0] bias_q;

  assign sum = {1'b0, shield_a} + {1'b0, shield_b};

  always_ff @(posedge clk) begin
    if (rst)       bias_q <= '0;
    else if (load) bias_q <= sum[PIX_W:1];
  end

  assign pix_out = (pix_in >= bias_q) ? pix_in - bias_q : '0;
endmodule

// File: rtl/rbc_frame_ram.sv
module rbc_frame_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/row_bias_corrector.sv
module row_bias_corrector
  import rbc_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int COLS  = 64,
  parameter int PIX_W = 8,
  localparam int FAW = $clog2(ROWS * COLS),
  localparam int HAW = FAW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  input  logic [HAW-1:0]   host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  output logic [PIX_W-1:0] host_rdata,
  output logic             busy
);
  localparam int CW = $clog2(COLS + SHIELD_PIX);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  rbc_state_e       state;
  logic [CW-1:0]    col;
  logic [RW-1:0]    row;
  logic             ctrl_sel;
  logic [PIX_W-1:0] line_pix, shield_a, shield_b, fixed_pix, ram_q;
  logic [FAW-1:0]   ram_waddr;
  logic             rd_ctrl_q, status_q;

  assign ctrl_sel = host_addr[HAW-1];

  rbc_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (host_wr && ctrl_sel),
    .pix_valid (pix_valid),
    .state     (state),
    .col       (col),
    .row       (row),
    .busy      (busy),
    .pix_ready (pix_ready)
  );

  rbc_line_store #(.COLS(COLS), .PIX_W(PIX_W)) u_line (
    .clk      (clk),
    .we       (state == ST_GET_ROW && pix_valid),
    .wcol     (col),
    .wdata    (pix_data),
    .rcol     (col),
    .rdata    (line_pix),
    .shield_a (shield_a),
    .shield_b (shield_b)
  );

  rbc_bias_fix #(.PIX_W(PIX_W)) u_fix (
    .clk      (clk),
    .rst      (rst),
    .load     (state == ST_CALC_BIAS),
    .shield_a (shield_a),
    .shield_b (shield_b),
    .pix_in   (line_pix),
    .pix_out  (fixed_pix)
  );

  assign ram_waddr = FAW'(row) * FAW'(COLS) + FAW'(col);

  rbc_frame_ram #(.DW(PIX_W), .DEPTH(ROWS * COLS)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (state == ST_FIX_ROW),
    .waddr (ram_waddr),
    .wdata (fixed_pix),
    .re    (host_rd && !ctrl_sel),
    .raddr (host_addr[FAW-1:0]),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ctrl_q <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      rd_ctrl_q <= host_rd && ctrl_sel;
      status_q  <= busy;
    end
  end

  assign host_rdata = rd_ctrl_q ? {{(PIX_W-1){1'b0}}, status_q} : ram_q;
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
  parameter int AW    = 13,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_ready,
  input logic [AW-1:0]    host_addr,
  input logic             host_wr,
  input logic             host_rd,
  input logic [PIX_W-1:0] host_rdata,
  input logic             busy
);
  a_r7_ready_inside_busy: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> busy);

  a_r5_busy_rises_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(host_wr && host_addr[AW-1]));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(host_wr && host_addr[AW-1])) |=> !busy);

  a_r8_intake_closed_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !pix_ready);

  a_r9_status_read: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(host_rd && host_addr[AW-1]))
      |-> host_rdata == {{(PIX_W-1){1'b0}}, $past(busy)});
endmodule

bind row_bias_corrector rbc_checker #(.AW(HAW), .PIX_W(PIX_W)) u_rbc_chk (
  .clk        (clk),
  .rst        (rst),
  .pix_ready  (pix_ready),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .busy       (busy)
);

// File: tb/row_bias_corrector_bench.sv
module row_bias_corrector_bench;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam logic [12:0] CTRL = 13'h1000;

  // row pattern: {base, step, shield0, shield1}
  localparam logic [31:0] PATS [8] = '{
    32'h0A03_0406, 32'h0004_C8C9, 32'hFF00_0000, 32'h0701_0304,
    32'h3205_FFFF, 32'h80FF_6465, 32'h0102_0102, 32'h5A07_09FE
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = 8'h00;
  logic        pix_ready;
  logic [12:0] host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  row_bias_corrector u_row_bias_corrector (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_rdata(host_rdata), .busy(busy)
  );

  function automatic logic [7:0] raw_pix(int pat, int c);
    logic [31:0] v = PATS[pat];
    return 8'(v[31:24] + v[23:16] * 8'(c));
  endfunction

  function automatic logic [7:0] exp_pix(int pat, int c);
    logic [31:0] v = PATS[pat];
    logic [8:0]  sum = {1'b0, v[15:8]} + {1'b0, v[7:0]};
    logic [7:0]  b = sum[8:1];
    logic [7:0]  p = raw_pix(pat, c);
    return (p >= b) ? p - b : 8'h00;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic push(input logic [7:0] d, input bit gap);
    if (gap) begin
      pix_valid = 1'b0;
      pix_data  = 8'hEE;
      @(negedge clk);
    end
    pix_valid = 1'b1;
    pix_data  = d;
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
    pix_valid = 1'b0;
    pix_data  = 8'h5C;
  endtask

  task automatic host_write(input logic [12:0] a);
    host_addr = a;
    host_wr   = 1'b1;
    @(negedge clk);
    host_wr   = 1'b0;
  endtask

  task automatic host_read(input logic [12:0] a, output logic [7:0] d);
    host_addr = a;
    host_rd   = 1'b1;
    @(negedge clk);
    host_rd   = 1'b0;
    d = host_rdata;
  endtask

  task automatic feed_frame(input int shift, input bit gaps);
    logic [7:0] st;
    for (int r = 0; r < ROWS; r++) begin
      int pat = (r + shift) % 8;
      for (int c = 0; c < COLS; c++) push(raw_pix(pat, c), gaps && (c % 3 == 1));
      push(PATS[pat][15:8], gaps);
      push(PATS[pat][7:0], 1'b0);
      if (r == 0) begin
        repeat (65) @(negedge clk);
        check(32'(pix_ready), 32'd0, "R7 ready still low 65 edges after shield");
        @(negedge clk);
        check(32'(pix_ready), 32'd1, "R7 ready back 66 edges after shield");
      end else if (r == 10) begin
        host_write(CTRL);
        host_read(CTRL, st);
        check(32'(st), 32'd1, "R9 status reads busy");
      end else if (r == ROWS - 1) begin
        repeat (65) @(negedge clk);
        check(32'(busy), 32'd1, "R8 busy still high 65 edges after last shield");
        @(negedge clk);
        check(32'(busy), 32'd0, "R8 busy low 66 edges after last shield");
      end
    end
  endtask

  task automatic readback(input int shift, input string tag);
    logic [7:0] d;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        host_read(13'(r * COLS + c), d);
        check(32'(d), 32'(exp_pix((r + shift) % 8, c)), tag);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog: busy=%0b expected 0", busy);
    report;
    $finish;
  end

  initial begin
    logic [7:0] st;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(32'(busy), 32'd0, "R10 busy after reset");
    check(32'(pix_ready), 32'd0, "R10 pix_ready after reset");
    check(32'(host_rdata), 32'd0, "R10 rdata after reset");

    // R6: data offered while not ready or not valid must not start intake
    pix_valid = 1'b1;
    pix_data  = 8'h77;
    @(negedge clk);
    pix_valid = 1'b0;
    check(32'(pix_ready), 32'd0, "R6 no intake while idle");

    host_write(CTRL);
    check(32'(busy), 32'd1, "R5 busy after start");
    check(32'(pix_ready), 32'd1, "R5 pix_ready after start");

    feed_frame(0, 1'b0);
    host_read(CTRL, st);
    check(32'(st), 32'd0, "R9 status reads idle");
    repeat (5) @(negedge clk);
    check(32'(busy), 32'd0, "R8 busy stays low");
    readback(0, "R1 R2 R3 R4 frame pixel");

    host_write(CTRL);
    check(32'(busy), 32'd1, "R5 second start");
    feed_frame(3, 1'b1);
    readback(3, "R6 R2 R3 stalled frame pixel");

    report;
    $finish;
  end
endmodule